// File: doc/BRIEF.md
# Partitioned Last-Level Cache

This block is a small last-level cache shared by four requesting cores. Each set holds one way reserved for each core and a pool of ways open to all of them. A request that finds its line in the requester's reserved way completes at once. A request that finds the line only in the common pool also completes at once, and the line moves into the requester's reserved way. A request that finds the line nowhere fetches it from main memory, one word per line, and installs it in the requester's reserved way.

Writes are held in the cache. A modified line reaches memory only when it is pushed out of the common pool. A reserved line that a fill displaces is not discarded: it drops into the common pool at the way a per-set rotating pointer selects. The line previously held there is written back if it is dirty. Requests are served one at a time, and a single handshake toward memory carries both write-backs and fills.

Top module: `pllc`

## Requirements
- R1: After reset, `req_ready_o` is high, and `rsp_valid_o` and `mem_req_o` are low. Every way is invalid, so the first access to any address is a miss.
- R2: A hit in the requester's own reserved way responds with kind 0 in the cycle after acceptance. It returns the word, moves no line and causes no memory traffic.
- R3: A hit in the common pool responds with kind 1 in the cycle after acceptance and causes no memory traffic. The line moves into the requester's reserved way. The requester's previous reserved line, with its dirty bit, takes the vacated pool way. If several pool ways match, the lowest-numbered one is used.
- R4: On a miss, a memory read at the request address is issued and held stable until `mem_ack_i`. The response comes with kind 2 in the cycle after that acknowledge, and the line is installed in the requester's reserved way.
- R5: When a fill displaces a valid reserved line, that line moves into the pool way chosen by the set's rotating pointer. The pointer steps 0, 1, 2, 3 and then wraps, and it advances only on such a displacement.
- R6: If the pool way chosen under R5 holds a valid dirty line, that line is written to memory at address {tag, index} before the fill read. Clean or invalid lines are dropped without traffic. No write-back occurs when the reserved way was empty.
- R7: A write updates the word and marks the line dirty. It causes no memory write at the time of the write.
- R8: A core never hits in, fills or evicts another core's reserved way.
- R9: `req_ready_o` is low from acceptance until the response. A `req_valid_i` seen while busy is ignored.
- R10: The set index is the low log2(SETS) address bits and the tag is the rest. Kind codes are 0 (own way), 1 (pool), 2 (miss), and 3 is never produced. `rsp_rdata_o` is the word as it stands after the operation, which for a write is the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle; request accepted on this cycle when valid |
| req_core_i | input | log2(NCORES) | Requesting core |
| req_addr_i | input | ADDR_W | Word address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle |
| rsp_kind_o | output | 2 | 0 own-way hit, 1 pool hit, 2 miss |
| rsp_rdata_o | output | DATA_W | Word after the operation |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Write-back data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | DATA_W | Fill data, valid with acknowledge |

## Verification
Two functions can land on the same set in one request. A fill can demote the requester's reserved line into the pool while the pool way it lands on must first be written back. Separately, a write that hits the pool updates the word in the same cycle that the line and its displaced partner trade places. Long read and write sweeps over few tags per set fill every pool way with dirty lines. This forces demotions to land on dirty victims and writes to hit lines that were demoted earlier. A reference model in the bench predicts, for each request, the kind, the returned word and the exact write-back address and data. Any swap or demotion that loses a dirty bit then surfaces as a wrong or missing write-back.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

  typedef enum logic [1:0] {
    KIND_OWN  = 2'd0,
    KIND_POOL = 2'd1,
    KIND_MISS = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_RESP
  } state_e;

endpackage

// File: rtl/pllc_store.sv
module pllc_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 8,
  parameter int ENT_W = 42
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [$clog2(SETS)-1:0]        set_i,
  output logic [WAYS-1:0][ENT_W-1:0]     ent_o,
  input  logic                           wa_en_i,
  input  logic [$clog2(WAYS)-1:0]        wa_way_i,
  input  logic [ENT_W-1:0]               wa_ent_i,
  input  logic                           wb_en_i,
  input  logic [$clog2(WAYS)-1:0]        wb_way_i,
  input  logic [ENT_W-1:0]               wb_ent_i
);

  logic [ENT_W-1:0] mem_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          mem_q[s][w] <= '0;
    end else begin
      if (wb_en_i) mem_q[set_i][wb_way_i] <= wb_ent_i;
      if (wa_en_i) mem_q[set_i][wa_way_i] <= wa_ent_i;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign ent_o[w] = mem_q[set_i][w];
  end

endmodule

// File: rtl/pllc_lookup.sv
module pllc_lookup #(
  parameter int NCORES  = 4,
  parameter int NSHARED = 4,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic [NCORES+NSHARED-1:0][TAG_W+DATA_W+1:0] set_i,
  input  logic [$clog2(NCORES)-1:0]                   core_i,
  input  logic [TAG_W-1:0]                            tag_i,
  output logic                                        own_hit_o,
  output logic                                        pool_hit_o,
  output logic [$clog2(NSHARED)-1:0]                  pool_idx_o,
  output logic [TAG_W+DATA_W+1:0]                     own_ent_o,
  output logic [TAG_W+DATA_W+1:0]                     pool_ent_o
);

  localparam int WAYS  = NCORES + NSHARED;
  localparam int WAY_W = $clog2(WAYS);
  localparam int SH_W  = $clog2(NSHARED);
  localparam int V_BIT = TAG_W + DATA_W + 1;

  logic [NSHARED-1:0] pool_match;

  assign own_ent_o = set_i[WAY_W'(core_i)];
  assign own_hit_o = own_ent_o[V_BIT] && (own_ent_o[DATA_W +: TAG_W] == tag_i);

  for (genvar g = 0; g < NSHARED; g++) begin : g_cmp
    assign pool_match[g] = set_i[NCORES+g][V_BIT] &&
                           (set_i[NCORES+g][DATA_W +: TAG_W] == tag_i);
  end

  // lowest matching pool way wins
  always_comb begin
    pool_idx_o = '0;
    for (int i = NSHARED - 1; i >= 0; i--)
      if (pool_match[i]) pool_idx_o = SH_W'(i);
  end

  assign pool_hit_o = |pool_match;
  assign pool_ent_o = set_i[WAY_W'(NCORES) + WAY_W'(pool_idx_o)];

endmodule

// File: rtl/pllc_rr.sv
module pllc_rr #(
  parameter int SETS    = 4,
  parameter int NSHARED = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [$clog2(SETS)-1:0]       set_i,
  input  logic                          adv_i,
  output logic [$clog2(NSHARED)-1:0]    ptr_o
);

  logic [$clog2(NSHARED)-1:0] ptr_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv_i) begin
      ptr_q[set_i] <= ptr_q[set_i] + 1'b1;
    end
  end

  assign ptr_o = ptr_q[set_i];

endmodule

// File: rtl/pllc.sv
module pllc #(
  parameter int SETS    = 4,
  parameter int NCORES  = 4,
  parameter int NSHARED = 4,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [$clog2(NCORES)-1:0] req_core_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic                      req_we_i,
  input  logic [DATA_W-1:0]         req_wdata_i,
  output logic                      rsp_valid_o,
  output logic [1:0]                rsp_kind_o,
  output logic [DATA_W-1:0]         rsp_rdata_o,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [DATA_W-1:0]         mem_wdata_o,
  input  logic                      mem_ack_i,
  input  logic [DATA_W-1:0]         mem_rdata_i
);
  import pllc_pkg::*;

  localparam int WAYS   = NCORES + NSHARED;
  localparam int CORE_W = $clog2(NCORES);
  localparam int SH_W   = $clog2(NSHARED);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int ENT_W  = TAG_W + DATA_W + 2;
  localparam int V_BIT  = ENT_W - 1;
  localparam int D_BIT  = ENT_W - 2;

  state_e                 state_q, state_d;
  logic [CORE_W-1:0]      core_q;
  logic [ADDR_W-1:0]      addr_q;
  logic                   we_q;
  logic [DATA_W-1:0]      wdata_q, rdata_q, fill_data;
  logic [IDX_W-1:0]       idx;
  logic [TAG_W-1:0]       tag;

  logic [WAYS-1:0][ENT_W-1:0] set_ent;
  logic                   wa_en, wb_en, rr_adv;
  logic [WAY_W-1:0]       wa_way, wb_way, victim_way;
  logic [ENT_W-1:0]       wa_ent, wb_ent, own_ent, pool_ent, victim_ent;
  logic                   own_hit, pool_hit;
  logic [SH_W-1:0]        pool_idx, rr_ptr;
  kind_e                  rsp_kind;

  assign idx = addr_q[IDX_W-1:0];
  assign tag = addr_q[ADDR_W-1:IDX_W];

  pllc_store #(.SETS(SETS), .WAYS(WAYS), .ENT_W(ENT_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (idx),
    .ent_o    (set_ent),
    .wa_en_i  (wa_en),
    .wa_way_i (wa_way),
    .wa_ent_i (wa_ent),
    .wb_en_i  (wb_en),
    .wb_way_i (wb_way),
    .wb_ent_i (wb_ent)
  );

  pllc_lookup #(.NCORES(NCORES), .NSHARED(NSHARED), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lookup (
    .set_i      (set_ent),
    .core_i     (core_q),
    .tag_i      (tag),
    .own_hit_o  (own_hit),
    .pool_hit_o (pool_hit),
    .pool_idx_o (pool_idx),
    .own_ent_o  (own_ent),
    .pool_ent_o (pool_ent)
  );

  pllc_rr #(.SETS(SETS), .NSHARED(NSHARED)) u_rr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (idx),
    .adv_i  (rr_adv),
    .ptr_o  (rr_ptr)
  );

  assign victim_way = WAY_W'(NCORES) + WAY_W'(rr_ptr);
  assign victim_ent = set_ent[victim_way];
  assign fill_data  = we_q ? wdata_q : mem_rdata_i;

  always_comb begin
    state_d     = state_q;
    wa_en       = 1'b0;
    wa_way      = WAY_W'(core_q);
    wa_ent      = '0;
    wb_en       = 1'b0;
    wb_way      = victim_way;
    wb_ent      = own_ent;
    rr_adv      = 1'b0;
    rsp_valid_o = 1'b0;
    rsp_kind    = KIND_MISS;
    rsp_rdata_o = rdata_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_q;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_LOOK;
      ST_LOOK: begin
        if (own_hit) begin
          rsp_valid_o = 1'b1;
          rsp_kind    = KIND_OWN;
          rsp_rdata_o = we_q ? wdata_q : own_ent[DATA_W-1:0];
          wa_en       = we_q;
          wa_ent      = {1'b1, 1'b1, tag, wdata_q};
          state_d     = ST_IDLE;
        end else if (pool_hit) begin
          // promote pool line, old own line takes the freed pool way
          rsp_valid_o = 1'b1;
          rsp_kind    = KIND_POOL;
          rsp_rdata_o = we_q ? wdata_q : pool_ent[DATA_W-1:0];
          wa_en       = 1'b1;
          wa_ent      = {pool_ent[V_BIT], pool_ent[D_BIT] | we_q,
                         pool_ent[DATA_W +: TAG_W],
                         we_q ? wdata_q : pool_ent[DATA_W-1:0]};
          wb_en       = 1'b1;
          wb_way      = WAY_W'(NCORES) + WAY_W'(pool_idx);
          wb_ent      = own_ent;
          state_d     = ST_IDLE;
        end else if (own_ent[V_BIT] && victim_ent[V_BIT] && victim_ent[D_BIT]) begin
          state_d = ST_WB;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {victim_ent[DATA_W +: TAG_W], idx};
        mem_wdata_o = victim_ent[DATA_W-1:0];
        if (mem_ack_i) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          wa_en   = 1'b1;
          wa_ent  = {1'b1, we_q, tag, fill_data};
          wb_en   = own_ent[V_BIT];
          rr_adv  = own_ent[V_BIT];
          state_d = ST_RESP;
        end
      end
      ST_RESP: begin
        rsp_valid_o = 1'b1;
        rsp_kind    = KIND_MISS;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      core_q  <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        core_q  <= req_core_i;
        addr_q  <= req_addr_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      if (state_q == ST_FILL && mem_ack_i) rdata_q <= fill_data;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_kind_o  = rsp_kind;

endmodule

// File: rtl/pllc_chk.sv
module pllc_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [1:0]        rsp_kind_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i
);

  // R9
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R9
  mem_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  // R9
  resp_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> req_ready_o);

  // R2
  hit_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o != 2'd2) |-> $past(req_valid_i && req_ready_o));

  // R4
  miss_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd2) |-> $past(mem_req_o && mem_ack_i && !mem_we_o));

  // R4
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R6
  wb_then_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=> (mem_req_o && !mem_we_o));

  // R10
  kind_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_kind_o != 2'd3));

endmodule

bind pllc pllc_chk #(.ADDR_W(ADDR_W)) u_pllc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_kind_o  (rsp_kind_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/pllc_test.sv
module pllc_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 4;
  localparam int NC = 4;
  localparam int NS = 4;
  localparam int ADDR_W = 10;
  localparam int MEM_LAT = 2;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [1:0] req_core = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready_o, rsp_valid_o, mem_req_o, mem_we_o;
  logic [1:0] rsp_kind_o;
  logic [31:0] rsp_rdata_o, mem_wdata_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pllc uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_core_i(req_core),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_kind_o(rsp_kind_o), .rsp_rdata_o(rsp_rdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int checks = 0, fails = 0;
  logic [31:0] mem [1 << ADDR_W];
  int wr_count = 0;
  int wr_addr = 0;
  logic [31:0] wr_data = '0;
  int lat_cnt = 0;

  // reference state
  bit mv [SETS][NC+NS];
  bit md [SETS][NC+NS];
  int mt [SETS][NC+NS];
  logic [31:0] mdat [SETS][NC+NS];
  int mrr [SETS];

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      lat_cnt = 0;
    end else if (mem_req_o) begin
      if (lat_cnt == MEM_LAT) begin
        mem_ack = 1'b1;
        if (mem_we_o) begin
          mem[mem_addr_o] = mem_wdata_o;
          wr_count++;
          wr_addr = int'(mem_addr_o);
          wr_data = mem_wdata_o;
        end else begin
          mem_rdata = mem[mem_addr_o];
        end
      end else begin
        lat_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic model(input int c, input int a, input bit we, input logic [31:0] wd,
                       output int k, output logic [31:0] rd, output bit wb,
                       output int wa, output logic [31:0] wdo);
    int s, t, hw, v;
    bit tv, td;
    int tt;
    logic [31:0] tdat;
    s = a % SETS; t = a / SETS; hw = -1;
    wb = 0; wa = 0; wdo = '0;
    if (mv[s][c] && mt[s][c] == t) begin
      k = 0;
      if (we) begin mdat[s][c] = wd; md[s][c] = 1; end
      rd = mdat[s][c];
    end else begin
      for (int w = NS - 1; w >= 0; w--)
        if (mv[s][NC+w] && mt[s][NC+w] == t) hw = NC + w;
      if (hw >= 0) begin
        k = 1;
        tv = mv[s][c]; td = md[s][c]; tt = mt[s][c]; tdat = mdat[s][c];
        mv[s][c] = 1; md[s][c] = md[s][hw] | we; mt[s][c] = t;
        mdat[s][c] = we ? wd : mdat[s][hw];
        mv[s][hw] = tv; md[s][hw] = td; mt[s][hw] = tt; mdat[s][hw] = tdat;
        rd = mdat[s][c];
      end else begin
        k = 2;
        if (mv[s][c]) begin
          v = NC + mrr[s];
          if (mv[s][v] && md[s][v]) begin
            wb = 1; wa = mt[s][v] * SETS + s; wdo = mdat[s][v];
          end
          mv[s][v] = 1; md[s][v] = md[s][c]; mt[s][v] = mt[s][c]; mdat[s][v] = mdat[s][c];
          mrr[s] = (mrr[s] + 1) % NS;
        end
        mv[s][c] = 1; md[s][c] = we; mt[s][c] = t;
        mdat[s][c] = we ? wd : mem[a];
        rd = mdat[s][c];
      end
    end
  endtask

  task automatic do_req(input int core, input int addr, input bit we, input logic [31:0] wd,
                        input string tag, input int want);
    int ek, ewa, wr0, n;
    logic [31:0] erd, ewd;
    bit ewb, busy_ok, got;
    logic [1:0] kind;
    logic [31:0] rdat;
    model(core, addr, we, wd, ek, erd, ewb, ewa, ewd);
    wr0 = wr_count;
    @(negedge clk);
    req_valid = 1'b1; req_core = 2'(core); req_addr = ADDR_W'(addr);
    req_we = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1; got = 0; n = 0;
    kind = 2'd3; rdat = '0;
    while (!got && n < 60) begin
      if (rsp_valid_o) begin
        got = 1; kind = rsp_kind_o; rdat = rsp_rdata_o;
      end else begin
        if (req_ready_o) busy_ok = 0;
        // poke while busy: must be ignored (R9)
        req_valid = 1'b1; req_core = 2'((core + 1) % NC);
        req_addr = ADDR_W'(addr) ^ 10'h3F0; req_we = 1'b1; req_wdata = 32'hBAD0BAD0;
        @(negedge clk);
        n++;
      end
    end
    req_valid = 1'b0;
    chk(got, "R9 response missing", 32'(n), 32'd60);
    chk(busy_ok, "R9 ready high while busy", 32'(busy_ok), 32'd1);
    case (ek)
      0: chk(kind == 2'(ek), "R2 kind", 32'(kind), 32'(ek));
      1: chk(kind == 2'(ek), "R3 kind", 32'(kind), 32'(ek));
      default: chk(kind == 2'(ek), "R4 kind", 32'(kind), 32'(ek));
    endcase
    if (ek != 2) chk(n == 0, "R2 hit latency", 32'(n), 32'd0);
    chk(rdat == erd, "R10 rdata", rdat, erd);
    if (want >= 0) chk(kind == 2'(want), tag, 32'(kind), 32'(want));
    if (ewb) begin
      chk(wr_count - wr0 == 1, "R6 write-back count", 32'(wr_count - wr0), 32'd1);
      chk(wr_addr == ewa, "R6 write-back addr", 32'(wr_addr), 32'(ewa));
      chk(wr_data == ewd, "R6 write-back data", wr_data, ewd);
    end else begin
      chk(wr_count == wr0, "R7 unexpected memory write", 32'(wr_count - wr0), 32'd0);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=%0d expected=<%0d", WD_CYCLES, WD_CYCLES);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = 32'hA5000000 ^ (a * 32'h00010193);
    for (int s = 0; s < SETS; s++) begin
      mrr[s] = 0;
      for (int w = 0; w < NC + NS; w++) begin
        mv[s][w] = 0; md[s][w] = 0; mt[s][w] = 0; mdat[s][w] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R1 ready after reset", 32'(req_ready_o), 32'd1);
    chk(rsp_valid_o == 1'b0, "R1 rsp idle after reset", 32'(rsp_valid_o), 32'd0);
    chk(mem_req_o == 1'b0, "R1 mem idle after reset", 32'(mem_req_o), 32'd0);

    // directed, set 1
    do_req(0, 21, 0, '0, "R1 first access misses", 2);
    do_req(0, 21, 0, '0, "R2 own hit", 0);
    do_req(0, 21, 1, 32'hDEAD0001, "R7 write hit", 0);
    do_req(1, 21, 0, '0, "R8 other core private not visible", 2);
    do_req(0, 21, 0, '0, "R8 private not evicted by other core", 0);
    do_req(0, 25, 0, '0, "R4 miss", 2);
    do_req(2, 21, 0, '0, "R5 demoted line in pool", 1);
    do_req(0, 21, 0, '0, "R3 line moved to core2", 2);

    // sweep: every core, every set, several tags, mixed writes
    for (int p = 0; p < 3; p++)
      for (int c = 0; c < NC; c++)
        for (int s = 0; s < SETS; s++)
          for (int t = 0; t < 6; t++)
            do_req(c, (c * 8 + t) * SETS + s, ((t + p) % 3) == 0,
                   32'(p * 4096 + c * 256 + s * 16 + t), "R5 sweep", -1);

    // cross-core reads of neighbours' lines
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < SETS; s++)
        for (int t = 0; t < 6; t++)
          do_req((c + 1) % NC, (c * 8 + t) * SETS + s, 0, '0, "R8 cross", -1);

    // pseudo-random mix over a small tag space
    lf = 16'hACE1;
    for (int i = 0; i < 700; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_req(int'(lf[1:0]), int'(lf[6:4]) * SETS + int'(lf[3:2]), lf[7] & lf[8],
             {lf, ~lf}, "R6 random", -1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule